// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block is the timing core of a small 8-bit processor. It steps every instruction through a series of machine cycles, and each machine cycle through its T-states. As it does so, it drives the bus control strobes and the bus address. Every instruction opens with an opcode fetch. Once the opcode byte has arrived, the instruction class presented on `instr_class` decides which cycles follow:

- A register move ends after the fetch.
- A 16-bit immediate load adds two memory reads.
- A subroutine call adds two reads of the target address. It then pushes the return address with two memory writes, each preceded by a one-T-state stack-pointer decrement.

A slow memory can hold `ready` low to stretch any bus cycle with wait T-states. The block also keeps the program counter, so bus addresses advance by themselves and a call redirects the next fetch to its target. A one-cycle `instr_done` pulse and a free-running T-state counter let the surrounding logic measure instruction lengths.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mcycle` is 0 (opcode fetch), `tstate` is 0 (T1), `addr` equals the reset program counter (0 by default) and `t_count` is 0.
- R2: An opcode fetch runs T1, T2, T3, T4 (`tstate` codes 0, 1, 3, 4) with `mcycle` = 0. `ale` is high only in T1. `rd_stb` is high from T1 through T3 and low in T4. `addr` holds the program counter from T1 through T3.
- R3: A memory read (`mcycle` = 1) runs T1, T2, T3 with `ale` in T1 and `rd_stb` high throughout. The program counter advances by one after each fetch and each read.
- R4: If `ready` is low at the end of T2 or of a wait state, the next T-state is a wait state (`tstate` = 2). During wait states `addr`, `rd_stb` and `wr_stb` keep their T2 values. The cycle moves on to T3 after `ready` is seen high.
- R5: A register move (class 0) lasts 4 T-states without waits. `instr_done` is high in its T4 only, and the next cycle is the T1 of a new fetch.
- R6: A 16-bit immediate load (class 1) lasts 10 T-states: a fetch, a read of the low byte at PC+1, then a read of the high byte at PC+2.
- R7: A call (class 2) lasts 18 T-states. The sequence is: fetch, low target read, high target read, a one-T-state decrement (`mcycle` = 3), a write of the return-address high byte at `sp_in`-1, another decrement, then a write of the low byte at `sp_in`-2 (modulo 2^16). The next fetch is from the target address.
- R8: `wr_stb` is high only in T2, wait states and T3 of a memory write (`mcycle` = 2). During a write, `ale` is high in T1, `rd_stb` stays low and `wr_data` carries the byte being pushed.
- R9: The class is taken at the end of fetch T3. Class code 3 is handled like a register move.
- R10: `t_count` increases by exactly one every clock cycle after reset, wait states included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| instr_class | input | 2 | Decoded class: 0 move, 1 immediate load, 2 call, 3 treated as move |
| ready | input | 1 | Memory ready; low requests wait states |
| sp_in | input | 16 | Current stack pointer value |
| rd_data | input | 8 | Data byte returned by memory in T3 of a read |
| mcycle | output | 2 | Machine cycle: 0 fetch, 1 read, 2 write, 3 stack decrement |
| tstate | output | 3 | T-state: 0 T1, 1 T2, 2 wait, 3 T3, 4 T4 |
| ale | output | 1 | Address latch strobe |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| addr | output | 16 | Bus address |
| wr_data | output | 8 | Byte driven during a write |
| instr_done | output | 1 | High in the final T-state of each instruction |
| t_count | output | 32 | Free-running T-state counter |

## Verification
A wrong step or T-state register shows up at the ports in the very cycle it goes wrong. The affected cycle's `mcycle`/`tstate` codes and strobes differ from the scoreboard entry for that clock. A mis-counted sequence also moves the `instr_done` pulse, so the measured instruction length no longer matches 4, 10 or 18 T-states plus the waits inserted. A corrupted program counter, stack pointer or target register appears as a wrong `addr` or `wr_data` in the next bus cycle that uses it, at the latest in the fetch that follows a call.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        CLS_MOVE   = 2'd0,
        CLS_LOAD16 = 2'd1,
        CLS_CALL   = 2'd2,
        CLS_SPARE  = 2'd3
    } instr_cls_e;

    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_READ  = 2'd1,
        MC_WRITE = 2'd2,
        MC_SPDEC = 2'd3
    } mcycle_e;

    typedef enum logic [2:0] {
        TS_T1 = 3'd0,
        TS_T2 = 3'd1,
        TS_TW = 3'd2,
        TS_T3 = 3'd3,
        TS_T4 = 3'd4
    } tstate_e;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_RD_LO = 3'd1,
        ST_RD_HI = 3'd2,
        ST_DEC_A = 3'd3,
        ST_WR_HI = 3'd4,
        ST_DEC_B = 3'd5,
        ST_WR_LO = 3'd6
    } step_e;

    typedef struct packed {
        logic ale;
        logic rd;
        logic wr;
    } strobe_t;

    // Last T-state of each machine cycle type (wait states are never last)
    function automatic tstate_e final_tstate(mcycle_e mc);
        case (mc)
            MC_FETCH: return TS_T4;
            MC_SPDEC: return TS_T1;
            default:  return TS_T3;
        endcase
    endfunction

    function automatic mcycle_e step_cycle(step_e s);
        case (s)
            ST_FETCH:           return MC_FETCH;
            ST_RD_LO, ST_RD_HI: return MC_READ;
            ST_WR_HI, ST_WR_LO: return MC_WRITE;
            default:            return MC_SPDEC;
        endcase
    endfunction

    function automatic logic is_bus(mcycle_e mc);
        return mc != MC_SPDEC;
    endfunction

endpackage

// File: rtl/bcs_tstate.sv
module bcs_tstate
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mcycle_e mc,
    input  logic    ready,
    output tstate_e ts,
    output logic    cyc_last
);

    tstate_e ts_nxt;

    always_comb begin
        cyc_last = (ts == final_tstate(mc));
        unique case (ts)
            TS_T1:        ts_nxt = cyc_last ? TS_T1 : TS_T2;
            TS_T2, TS_TW: ts_nxt = ready ? TS_T3 : TS_TW;
            TS_T3:        ts_nxt = cyc_last ? TS_T1 : TS_T4;
            TS_T4:        ts_nxt = TS_T1;
            default:      ts_nxt = TS_T1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ts <= TS_T1;
        else     ts <= ts_nxt;
    end

endmodule

// File: rtl/bcs_mcseq.sv
module bcs_mcseq
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] instr_class,
    input  tstate_e    ts,
    input  logic       cyc_last,
    output step_e      step,
    output mcycle_e    mc,
    output logic       instr_end
);

    instr_cls_e cls_q;
    step_e      step_nxt;
    logic       has_reads;
    logic       is_call;

    always_comb begin
        has_reads = (cls_q == CLS_LOAD16) || (cls_q == CLS_CALL);
        is_call   = (cls_q == CLS_CALL);
        step_nxt  = step;
        if (cyc_last) begin
            unique case (step)
                ST_FETCH: step_nxt = has_reads ? ST_RD_LO : ST_FETCH;
                ST_RD_LO: step_nxt = ST_RD_HI;
                ST_RD_HI: step_nxt = is_call ? ST_DEC_A : ST_FETCH;
                ST_DEC_A: step_nxt = ST_WR_HI;
                ST_WR_HI: step_nxt = ST_DEC_B;
                ST_DEC_B: step_nxt = ST_WR_LO;
                ST_WR_LO: step_nxt = ST_FETCH;
                default:  step_nxt = ST_FETCH;
            endcase
        end
        mc        = step_cycle(step);
        instr_end = cyc_last && (step_nxt == ST_FETCH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= ST_FETCH;
            cls_q <= CLS_MOVE;
        end else begin
            step <= step_nxt;
            // opcode byte is on the bus in fetch T3: class becomes valid here
            if (step == ST_FETCH && ts == TS_T3)
                cls_q <= instr_cls_e'(instr_class);
        end
    end

endmodule

// File: rtl/bcs_busdrv.sv
module bcs_busdrv
    import bcs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  mcycle_e           mc,
    input  tstate_e           ts,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] rd_data,
    output strobe_t           stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] sp_work;
    logic [DATA_W-1:0] tgt_lo;
    logic [DATA_W-1:0] tgt_hi;
    logic              rd_cycle;
    logic              wr_mid;

    always_comb begin
        rd_cycle = (mc == MC_FETCH) || (mc == MC_READ);
        wr_mid   = (ts == TS_T2) || (ts == TS_TW) || (ts == TS_T3);
        stb.ale  = is_bus(mc) && (ts == TS_T1);
        stb.rd   = rd_cycle && (ts != TS_T4);
        stb.wr   = (mc == MC_WRITE) && wr_mid;
        addr     = rd_cycle ? pc : sp_work;
        wr_data  = (step == ST_WR_HI) ? pc[ADDR_W-1:DATA_W] : pc[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= RESET_PC;
            sp_work <= '0;
            tgt_lo  <= '0;
            tgt_hi  <= '0;
        end else begin
            if (rd_cycle && ts == TS_T3)
                pc <= pc + 1'b1;
            if (step == ST_RD_LO && ts == TS_T3)
                tgt_lo <= rd_data;
            if (step == ST_RD_HI && ts == TS_T3)
                tgt_hi <= rd_data;
            if (step == ST_DEC_A)
                sp_work <= sp_in - 1'b1;
            if (step == ST_DEC_B)
                sp_work <= sp_work - 1'b1;
            if (step == ST_WR_LO && ts == TS_T3)
                pc <= {tgt_hi, tgt_lo};
        end
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TCNT_W = 32,
    parameter logic [2*DATA_W-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           instr_class,
    input  logic                 ready,
    input  logic [2*DATA_W-1:0]  sp_in,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [1:0]           mcycle,
    output logic [2:0]           tstate,
    output logic                 ale,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic [2*DATA_W-1:0]  addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 instr_done,
    output logic [TCNT_W-1:0]    t_count
);

    localparam int ADDR_W = 2 * DATA_W;

    tstate_e ts;
    mcycle_e mc;
    step_e   step;
    logic    cyc_last;
    strobe_t stb;

    bcs_tstate u_tstate (
        .clk      (clk),
        .rst      (rst),
        .mc       (mc),
        .ready    (ready),
        .ts       (ts),
        .cyc_last (cyc_last)
    );

    bcs_mcseq u_mcseq (
        .clk         (clk),
        .rst         (rst),
        .instr_class (instr_class),
        .ts          (ts),
        .cyc_last    (cyc_last),
        .step        (step),
        .mc          (mc),
        .instr_end   (instr_done)
    );

    bcs_busdrv #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_busdrv (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .mc      (mc),
        .ts      (ts),
        .sp_in   (sp_in),
        .rd_data (rd_data),
        .stb     (stb),
        .addr    (addr),
        .wr_data (wr_data)
    );

    always_comb begin
        mcycle = mc;
        tstate = ts;
        ale    = stb.ale;
        rd_stb = stb.rd;
        wr_stb = stb.wr;
    end

    always_ff @(posedge clk) begin
        if (rst) t_count <= '0;
        else     t_count <= t_count + 1'b1;
    end

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TCNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic [1:0]        mcycle,
    input logic [2:0]        tstate,
    input logic              ale,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] addr,
    input logic              instr_done,
    input logic [TCNT_W-1:0] t_count
);

    p_fetch_t4_r2: assert property (@(posedge clk) disable iff (rst)
        (mcycle == MC_FETCH && tstate == TS_T3) |=> (tstate == TS_T4 && !rd_stb && !ale));

    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_wait_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (tstate == TS_T2 && !ready) |=> (tstate == TS_TW));

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tstate == TS_TW) |-> ($stable(addr) && $stable(rd_stb) && $stable(wr_stb)));

    p_next_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> (mcycle == MC_FETCH && tstate == TS_T1 && ale));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    p_tcount_step_r10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (t_count == $past(t_count) + 1'b1));

endmodule

bind bus_cycle_seq bcs_checker #(
    .ADDR_W (ADDR_W),
    .TCNT_W (TCNT_W)
) u_bcs_checker (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .mcycle     (mcycle),
    .tstate     (tstate),
    .ale        (ale),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .addr       (addr),
    .instr_done (instr_done),
    .t_count    (t_count)
);

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  instr_class = 2'd0;
    logic        ready = 1'b1;
    logic [15:0] sp_in = 16'h0;
    logic [7:0]  rd_data = 8'h0;
    logic [1:0]  mcycle;
    logic [2:0]  tstate;
    logic        ale, rd_stb, wr_stb, instr_done;
    logic [15:0] addr;
    logic [7:0]  wr_data;
    logic [31:0] t_count;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst(rst), .instr_class(instr_class), .ready(ready),
        .sp_in(sp_in), .rd_data(rd_data), .mcycle(mcycle), .tstate(tstate),
        .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
        .wr_data(wr_data), .instr_done(instr_done), .t_count(t_count)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        logic [1:0]  mc;
        logic [2:0]  ts;
        logic        ale, rd, wr, done, chk_a, chk_d;
        logic [15:0] a;
        logic [7:0]  d;
        int          req;
    } exp_t;

    exp_t        exp_q[$];
    logic        stim_rdy[$];
    logic [7:0]  stim_dat[$];
    int          len_q[$];
    int          lreq_q[$];

    int          checks = 0;
    int          fails = 0;
    int          tlen;
    int          tcnt_exp = 0;
    int          since = 0;
    logic [15:0] m_pc = 16'h0;
    logic        finished = 1'b0;

    task automatic add_ts(input logic [1:0] mc, input logic [2:0] ts,
                          input logic a_l, input logic r, input logic w, input logic dn,
                          input logic ca, input logic [15:0] a, input logic cd,
                          input logic [7:0] d, input logic rdy, input int req);
        exp_t e;
        e.mc = mc; e.ts = ts; e.ale = a_l; e.rd = r; e.wr = w; e.done = dn;
        e.chk_a = ca; e.a = a; e.chk_d = cd; e.d = d; e.req = req;
        exp_q.push_back(e);
        stim_rdy.push_back(rdy);
        stim_dat.push_back(d);
        tlen++;
    endtask

    // One bus cycle; nw wait states requested at the end of T2 (R4 entries)
    task automatic gen_bus(input logic [1:0] mc, input logic [15:0] a, input logic [7:0] bv,
                           input int nw, input logic last, input int req);
        logic w, r;
        w = (mc == 2'd2);
        r = !w;
        add_ts(mc, 3'd0, 1'b1, r, 1'b0, 1'b0, 1'b1, a, w, bv, 1'b1, req);
        add_ts(mc, 3'd1, 1'b0, r, w, 1'b0, 1'b1, a, w, bv, nw == 0, req);
        for (int k = 0; k < nw; k++)
            add_ts(mc, 3'd2, 1'b0, r, w, 1'b0, 1'b1, a, w, bv, k == nw - 1, 4);
        add_ts(mc, 3'd3, 1'b0, r, w, last && (mc != 2'd0), 1'b1, a, w, bv, 1'b1, req);
        if (mc == 2'd0)
            add_ts(mc, 3'd4, 1'b0, 1'b0, 1'b0, last, 1'b0, a, 1'b0, 8'h0, 1'b1, req);
    endtask

    task automatic gen_dec();
        add_ts(2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 1'b1, 7);
    endtask

    // Driver: builds the expected T-state stream, then drives the inputs
    task automatic run_instr(input logic [1:0] cls, input int wb, input int nw,
                             input logic [7:0] lo, input logic [7:0] hi, input logic [15:0] sp);
        logic [15:0] ret;
        int lreq;
        tlen = 0;
        if (cls == 2'd0 || cls == 2'd3) begin          // R5, R9
            gen_bus(2'd0, m_pc, 8'h0, (wb == 0) ? nw : 0, 1'b1, (cls == 2'd3) ? 9 : 2);
            m_pc = m_pc + 16'd1;
            lreq = (cls == 2'd3) ? 9 : 5;
        end else begin
            gen_bus(2'd0, m_pc, 8'h0, (wb == 0) ? nw : 0, 1'b0, 2);
            m_pc = m_pc + 16'd1;
            gen_bus(2'd1, m_pc, lo, (wb == 1) ? nw : 0, 1'b0, 3);   // R3, low byte first (R6)
            m_pc = m_pc + 16'd1;
            gen_bus(2'd1, m_pc, hi, (wb == 2) ? nw : 0, cls == 2'd1, 6);
            m_pc = m_pc + 16'd1;
            lreq = 6;
            if (cls == 2'd2) begin                     // R7 push order, R8 write strobes
                ret = m_pc;
                gen_dec();
                gen_bus(2'd2, sp - 16'd1, ret[15:8], (wb == 3) ? nw : 0, 1'b0, 8);
                gen_dec();
                gen_bus(2'd2, sp - 16'd2, ret[7:0], (wb == 4) ? nw : 0, 1'b1, 8);
                m_pc = {hi, lo};
                lreq = 7;
            end
        end
        len_q.push_back(tlen);
        lreq_q.push_back(lreq);
        while (stim_rdy.size() > 0) begin
            ready = stim_rdy.pop_front();
            rd_data = stim_dat.pop_front();
            instr_class = cls;
            sp_in = sp;
            @(posedge clk); #1;
        end
    endtask

    // Monitor: pops one expected T-state per clock and compares
    always @(negedge clk) begin : mon
        exp_t e;
        int L, lr;
        logic bad;
        if (!rst && !finished && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            bad = (mcycle !== e.mc) || (tstate !== e.ts) || (ale !== e.ale) ||
                  (rd_stb !== e.rd) || (wr_stb !== e.wr) || (instr_done !== e.done) ||
                  (e.chk_a && addr !== e.a) || (e.chk_d && wr_data !== e.d);
            if (bad) begin
                fails++;
                $display("FAIL R%0d t=%0d: got mc=%0d ts=%0d ale=%b rd=%b wr=%b done=%b addr=%h wd=%h; exp mc=%0d ts=%0d ale=%b rd=%b wr=%b done=%b addr=%h wd=%h",
                         e.req, tcnt_exp, mcycle, tstate, ale, rd_stb, wr_stb, instr_done, addr, wr_data,
                         e.mc, e.ts, e.ale, e.rd, e.wr, e.done, e.a, e.d);
            end
            checks++;   // R10 free-running count
            if (t_count !== tcnt_exp) begin
                fails++;
                $display("FAIL R10 t_count got %0d exp %0d", t_count, tcnt_exp);
            end
            tcnt_exp++;
            since++;
            if (instr_done && len_q.size() > 0) begin   // R5/R6/R7 totals
                L = len_q.pop_front();
                lr = lreq_q.pop_front();
                checks++;
                if (since != L) begin
                    fails++;
                    $display("FAIL R%0d instruction length got %0d exp %0d", lr, since, L);
                end
                since = 0;
            end
        end
    end

    task automatic check_reset(input logic [31:0] got, input logic [31:0] expv, input string what);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL R1 %s got %h exp %h", what, got, expv);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_reset({30'd0, mcycle}, 32'd0, "mcycle");
        check_reset({29'd0, tstate}, 32'd0, "tstate");
        check_reset({16'd0, addr}, 32'd0, "addr");
        check_reset(t_count, 32'd0, "t_count");
        @(posedge clk); #1;
        rst = 1'b0;
        run_instr(2'd0, -1, 0, 8'h00, 8'h00, 16'h2000);   // R5 move
        run_instr(2'd1, -1, 0, 8'h34, 8'h12, 16'h2000);   // R6 load
        run_instr(2'd2, -1, 0, 8'h00, 8'h40, 16'h2000);   // R7 call to 4000
        run_instr(2'd0, 0, 2, 8'h00, 8'h00, 16'h2000);    // R4 waits in fetch
        run_instr(2'd1, 2, 3, 8'hCD, 8'hAB, 16'h2000);    // R4 waits in high read
        run_instr(2'd2, 3, 1, 8'h10, 8'h90, 16'h0001);    // R7 stack wrap, R8 write wait
        run_instr(2'd3, -1, 0, 8'h00, 8'h00, 16'h0001);   // R9 spare class
        run_instr(2'd0, 0, 1, 8'h00, 8'h00, 16'h0001);    // R4 single wait
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule